// File: doc/BRIEF.md
# Hardware Semaphore Command Unit

This unit holds a bank of 32 counting semaphores, each 12 bits wide, shared by several DMA channels. Each channel presents a 32-bit command word over a valid/ready pair. Commands that set, raise or lower a semaphore complete in the cycle they are presented. Commands that wait on a condition keep ready low until the condition holds and are then granted. The conditions are equality, greater-or-equal, and "above zero, then take one".

A separate update port lets the compute side change any semaphore so that blocked waits can move on. In any cycle, at most one channel command is granted. The grant goes to the lowest-numbered channel whose command can complete in that cycle. A channel whose wait is still blocked never holds back a channel above it. A flag in the word that marks the command as gating the transfer is handed back to the requester unchanged.

Top module: `sem_cmd_unit`

## Requirements
- R1: After reset every semaphore reads zero, and no ready is asserted for a channel without valid.
- R2: A word with bit 31 clear (disabled), or an enabled word with operation 0 (no-op), is granted in the cycle it is presented. It changes no semaphore and raises no error.
- R3: Operation 1 (bits 26:24) sets the semaphore selected by bits 20:16 to the immediate in bits 11:0.
- R4: Operation 2 adds one and saturates at 0xFFF. Operation 3 subtracts one and saturates at zero.
- R5: Operation 4 (wait equal to the immediate) and operation 5 (wait greater than or equal to the immediate) hold ready low while the condition is false. They are granted in the first cycle it is true and leave the semaphore unchanged.
- R6: Operation 6 is granted only while the semaphore is non-zero. In the same cycle as the grant it decrements the semaphore by one.
- R7: Operation 7 is granted at once with the error output high and leaves all semaphores unchanged.
- R8: Bit 22 of each channel's word appears on that channel's pre-sync output.
- R9: At most one channel is granted per cycle. The grant goes to the lowest-indexed valid channel whose command can complete, and blocked waits do not block other channels.
- R10: The update port applies set (op 0), add-one (op 1, saturating) or subtract-one (op 2, saturating) to the indexed semaphore; op 3 changes nothing. When an update and a command hit the same semaphore in one cycle, the command sees the updated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | NUM_CH | Command valid per channel |
| cmd_word_i | input | NUM_CH*32 | Command words, channel n in bits 32n+31:32n |
| cmd_ready_o | output | NUM_CH | Grant per channel; the command completes on the clock edge |
| cmd_err_o | output | NUM_CH | Reserved-operation error, valid with ready |
| cmd_pre_o | output | NUM_CH | Pre-sync flag of each channel's word |
| upd_valid_i | input | 1 | External update strobe |
| upd_op_i | input | 2 | Update kind: 0 set, 1 add one, 2 subtract one, 3 none |
| upd_idx_i | input | 5 | Semaphore index for the update |
| upd_val_i | input | 12 | Value for the set update |

## Verification
The bench probes semaphore values through equality waits, which are granted only on a match. It targets the saturation ends 0 and 0xFFF, where a wrapping adder would read back as 0x000 or 0xFFF. It also sends a take-one to a zero semaphore, which a broken design would grant and wrap. Two channels race for a semaphore holding one: a design that lacks atomic test-and-decrement, or that uses the wrong priority, grants both or the wrong one. Updates that collide with a command on the same index expose a design that orders the two the wrong way. Such a design stalls a wait that should pass, or grants a take-one that should stall.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int CMD_W   = 32;
  localparam int VAL_W   = 12;
  localparam int SEM_N   = 32;
  localparam int IDX_W   = $clog2(SEM_N);
  localparam int EN_BIT  = 31;
  localparam int PRE_BIT = 22;
  localparam int OP_LSB  = 24;
  localparam int IDX_LSB = 16;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_INIT = 3'd1,
    OP_INC  = 3'd2,
    OP_DEC  = 3'd3,
    OP_WEQ  = 3'd4,
    OP_WGE  = 3'd5,
    OP_TAKE = 3'd6,
    OP_RSV  = 3'd7
  } sem_op_e;

  typedef enum logic [1:0] {
    UPD_SET  = 2'd0,
    UPD_INC  = 2'd1,
    UPD_DEC  = 2'd2,
    UPD_NONE = 2'd3
  } upd_op_e;

  typedef logic [VAL_W-1:0] sem_val_t;

  typedef struct packed {
    logic             en;
    logic             pre;
    sem_op_e          op;
    logic [IDX_W-1:0] idx;
    sem_val_t         val;
  } sem_cmd_t;

  function automatic sem_cmd_t unpack_cmd(input logic [CMD_W-1:0] w);
    sem_cmd_t c;
    c.en  = w[EN_BIT];
    c.pre = w[PRE_BIT];
    c.op  = sem_op_e'(w[OP_LSB +: 3]);
    c.idx = w[IDX_LSB +: IDX_W];
    c.val = w[VAL_W-1:0];
    return c;
  endfunction

  function automatic sem_val_t sat_inc(input sem_val_t v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  function automatic sem_val_t sat_dec(input sem_val_t v);
    return (v == '0) ? v : v - 1'b1;
  endfunction
endpackage

// File: rtl/sem_decode.sv
module sem_decode
  import sem_pkg::*;
(
  input  logic                        valid_i,
  input  logic [CMD_W-1:0]            word_i,
  input  logic [SEM_N-1:0][VAL_W-1:0] sem_i,
  output sem_cmd_t                    cmd_o,
  output logic                        elig_o
);
  sem_cmd_t cmd;
  sem_val_t cur;
  logic     cond;
  logic     unused_bits;

  assign cmd         = unpack_cmd(word_i);
  assign cur         = sem_i[cmd.idx];
  assign unused_bits = ^{word_i[30:27], word_i[23], word_i[21], word_i[15:12]};

  always_comb begin
    cond = 1'b1;
    if (cmd.en) begin
      unique case (cmd.op)
        OP_WEQ:  cond = (cur == cmd.val);
        OP_WGE:  cond = (cur >= cmd.val);
        OP_TAKE: cond = (cur != '0);
        default: cond = 1'b1;
      endcase
    end
  end

  assign cmd_o  = cmd;
  assign elig_o = valid_i & cond;
endmodule

// File: rtl/sem_arb.sv
module sem_arb #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // isolate lowest set bit
  assign gnt_o = req_i & (~req_i + 1'b1);

  p_gnt_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_gnt_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> (gnt_o != '0));
  p_gnt_subset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        upd_valid_i,
  input  upd_op_e                     upd_op_i,
  input  logic [IDX_W-1:0]            upd_idx_i,
  input  sem_val_t                    upd_val_i,
  input  logic                        fire_i,
  input  sem_cmd_t                    cmd_i,
  output logic [SEM_N-1:0][VAL_W-1:0] view_o
);
  logic [SEM_N-1:0][VAL_W-1:0] sem_q, sem_d, view;

  // update stage first, command stage sees its result
  always_comb begin
    view = sem_q;
    if (upd_valid_i) begin
      unique case (upd_op_i)
        UPD_SET: view[upd_idx_i] = upd_val_i;
        UPD_INC: view[upd_idx_i] = sat_inc(sem_q[upd_idx_i]);
        UPD_DEC: view[upd_idx_i] = sat_dec(sem_q[upd_idx_i]);
        default: ;
      endcase
    end
  end

  always_comb begin
    sem_d = view;
    if (fire_i && cmd_i.en) begin
      unique case (cmd_i.op)
        OP_INIT: sem_d[cmd_i.idx] = cmd_i.val;
        OP_INC:  sem_d[cmd_i.idx] = sat_inc(view[cmd_i.idx]);
        OP_DEC,
        OP_TAKE: sem_d[cmd_i.idx] = sat_dec(view[cmd_i.idx]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sem_q <= '0;
    else         sem_q <= sem_d;
  end

  assign view_o = view;

  p_rsv_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && cmd_i.en && cmd_i.op == OP_RSV && !upd_valid_i |=> $stable(sem_q));
  p_wait_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && cmd_i.en && (cmd_i.op == OP_WEQ || cmd_i.op == OP_WGE) && !upd_valid_i
    |=> $stable(sem_q));
  p_take_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && cmd_i.en && cmd_i.op == OP_TAKE |-> view[cmd_i.idx] != '0);
  p_dec_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && cmd_i.en && cmd_i.op == OP_DEC && view[cmd_i.idx] == '0
    |=> sem_q[$past(cmd_i.idx)] == '0);
  p_inc_ceiling_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && cmd_i.en && cmd_i.op == OP_INC && view[cmd_i.idx] == '1
    |=> sem_q[$past(cmd_i.idx)] == '1);
endmodule

// File: rtl/sem_cmd_unit.sv
module sem_cmd_unit
  import sem_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH-1:0]       cmd_valid_i,
  input  logic [NUM_CH*CMD_W-1:0] cmd_word_i,
  output logic [NUM_CH-1:0]       cmd_ready_o,
  output logic [NUM_CH-1:0]       cmd_err_o,
  output logic [NUM_CH-1:0]       cmd_pre_o,
  input  logic                    upd_valid_i,
  input  logic [1:0]              upd_op_i,
  input  logic [IDX_W-1:0]        upd_idx_i,
  input  logic [VAL_W-1:0]        upd_val_i
);
  logic [SEM_N-1:0][VAL_W-1:0] view;
  sem_cmd_t                    cmds [NUM_CH];
  logic [NUM_CH-1:0]           elig, gnt;
  sem_cmd_t                    sel;
  logic                        fire;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    sem_decode i_dec (
      .valid_i (cmd_valid_i[i]),
      .word_i  (cmd_word_i[i*CMD_W +: CMD_W]),
      .sem_i   (view),
      .cmd_o   (cmds[i]),
      .elig_o  (elig[i])
    );
    assign cmd_err_o[i] = gnt[i] & cmds[i].en & (cmds[i].op == OP_RSV);
    assign cmd_pre_o[i] = cmds[i].pre;
  end

  sem_arb #(.N(NUM_CH)) i_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (elig),
    .gnt_o  (gnt)
  );

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (gnt[i]) sel = cmds[i];
  end

  assign fire        = |gnt;
  assign cmd_ready_o = gnt;

  sem_bank i_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_valid_i (upd_valid_i),
    .upd_op_i    (upd_op_e'(upd_op_i)),
    .upd_idx_i   (upd_idx_i),
    .upd_val_i   (upd_val_i),
    .fire_i      (fire),
    .cmd_i       (sel),
    .view_o      (view)
  );

  p_ready_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o & ~cmd_valid_i) == '0);
  p_err_with_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_err_o & ~cmd_ready_o) == '0);
endmodule

// File: tb/test_sem_cmd_unit.sv
`timescale 1ns/1ps
module test_sem_cmd_unit;
  localparam int NCH = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  cmd_valid = '0;
  logic [NCH*32-1:0] cmd_word = '0;
  logic [NCH-1:0]  cmd_ready, cmd_err, cmd_pre;
  logic            upd_valid = 1'b0;
  logic [1:0]      upd_op = 2'd3;
  logic [4:0]      upd_idx = '0;
  logic [11:0]     upd_val = '0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sem_cmd_unit #(.NUM_CH(NCH)) i_sem_cmd_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word),
    .cmd_ready_o(cmd_ready), .cmd_err_o(cmd_err), .cmd_pre_o(cmd_pre),
    .upd_valid_i(upd_valid), .upd_op_i(upd_op), .upd_idx_i(upd_idx), .upd_val_i(upd_val)
  );

  function automatic logic [31:0] mk(input bit en, input bit pre, input logic [2:0] op,
                                     input logic [4:0] idx, input logic [11:0] v);
    logic [31:0] w;
    w = '0;
    w[31] = en; w[22] = pre; w[26:24] = op; w[20:16] = idx; w[11:0] = v;
    return w;
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    if (!w[31]) return "R2";
    case (w[26:24])
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  typedef struct packed { logic [31:0] w; logic rdy; logic err; logic pre; } vec_t;
  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    {mk(1,0,1,3,5),        3'b100},
    {mk(1,1,4,3,5),        3'b101},
    {mk(1,0,2,3,0),        3'b100},
    {mk(1,0,4,3,6),        3'b100},
    {mk(1,0,4,3,5),        3'b000},
    {mk(1,0,3,3,0),        3'b100},
    {mk(1,0,5,3,5),        3'b100},
    {mk(1,1,5,3,6),        3'b001},
    {mk(1,0,6,3,0),        3'b100},
    {mk(1,0,4,3,4),        3'b100},
    {mk(1,0,1,7,0),        3'b100},
    {mk(1,0,6,7,0),        3'b000},
    {mk(1,0,3,7,0),        3'b100},
    {mk(1,0,4,7,0),        3'b100},
    {mk(1,0,1,7,12'hFFE),  3'b100},
    {mk(1,0,2,7,0),        3'b100},
    {mk(1,0,2,7,0),        3'b100},
    {mk(1,0,4,7,12'hFFF),  3'b100},
    {mk(1,0,7,7,0),        3'b110},
    {mk(1,0,4,7,12'hFFF),  3'b100},
    {mk(0,1,1,7,0),        3'b101},
    {mk(1,0,0,7,5),        3'b100},
    {mk(1,0,4,7,12'hFFF),  3'b100}
  };

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [NCH-1:0] v, input logic [31:0] w0, input logic [31:0] w1,
                       input logic [31:0] w2, input logic [31:0] w3);
    @(negedge clk);
    cmd_valid = v;
    cmd_word  = {w3, w2, w1, w0};
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    cmd_valid = '0;
    upd_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk); #1;
    chk("R1", "ready idle", cmd_ready, '0);
    drive(4'b0001, mk(1,0,4,0,0), 0, 0, 0);
    chk("R1", "s0 zero", cmd_ready, 4'b0001);
    drive(4'b0001, mk(1,0,4,31,0), 0, 0, 0);
    chk("R1", "s31 zero", cmd_ready, 4'b0001);

    for (int k = 0; k < NV; k++) begin
      drive(4'b0001, TBL[k].w, 0, 0, 0);
      chk(tag_of(TBL[k].w), $sformatf("vec %0d ready", k), cmd_ready[0], TBL[k].rdy);
      chk("R7", $sformatf("vec %0d err", k), cmd_err[0], TBL[k].err);
      chk("R8", $sformatf("vec %0d pre", k), cmd_pre[0], TBL[k].pre);
    end

    // R9 priority and atomic take
    drive(4'b0001, mk(1,0,1,9,1), 0, 0, 0);
    drive(4'b1111, mk(1,0,4,9,7), mk(1,0,6,9,0), mk(1,0,6,9,0), mk(1,0,1,12,2));
    chk("R9", "first grant", cmd_ready, 4'b0010);
    drive(4'b1100, 0, 0, mk(1,0,6,9,0), mk(1,0,1,12,2));
    chk("R9", "stalled take skipped", cmd_ready, 4'b1000);
    drive(4'b0001, mk(1,0,4,9,0), 0, 0, 0);
    chk("R6", "s9 taken once", cmd_ready, 4'b0001);
    drive(4'b0001, mk(1,0,4,12,2), 0, 0, 0);
    chk("R9", "ch3 init applied", cmd_ready, 4'b0001);

    // R10 external updates
    idle();
    upd_valid = 1'b1; upd_op = 2'd0; upd_idx = 5'd10; upd_val = 12'd3;
    drive(4'b0000, 0, 0, 0, 0);
    @(negedge clk); upd_valid = 1'b0;
    cmd_valid = 4'b0001; cmd_word = {96'h0, mk(1,0,4,10,3)}; #1;
    chk("R10", "set update", cmd_ready, 4'b0001);
    @(negedge clk); upd_valid = 1'b1; upd_op = 2'd1; upd_idx = 5'd10;
    cmd_word = {96'h0, mk(1,0,4,10,4)}; #1;
    chk("R10", "inc before cmd", cmd_ready, 4'b0001);
    @(negedge clk); upd_op = 2'd2;
    cmd_word = {96'h0, mk(1,0,4,10,3)}; #1;
    chk("R10", "dec before cmd", cmd_ready, 4'b0001);
    @(negedge clk); upd_op = 2'd3; upd_val = 12'd9;
    cmd_word = {96'h0, mk(1,0,4,10,3)}; #1;
    chk("R10", "op3 no change", cmd_ready, 4'b0001);
    @(negedge clk); upd_valid = 1'b0;
    cmd_word = {96'h0, mk(1,0,1,11,2)}; #1;
    @(negedge clk); upd_valid = 1'b1; upd_op = 2'd0; upd_idx = 5'd11; upd_val = 12'd0;
    cmd_word = {96'h0, mk(1,0,6,11,0)}; #1;
    chk("R10", "take sees cleared", cmd_ready, 4'b0000);
    @(negedge clk); upd_valid = 1'b0;
    cmd_word = {96'h0, mk(1,0,4,11,0)}; #1;
    chk("R10", "s11 zero", cmd_ready, 4'b0001);
    @(negedge clk); cmd_valid = '0; upd_valid = 1'b1; upd_op = 2'd0; upd_idx = 5'd13; upd_val = 12'hFFF;
    @(negedge clk); upd_op = 2'd1;
    @(negedge clk); upd_valid = 1'b0;
    cmd_valid = 4'b0001; cmd_word = {96'h0, mk(1,0,4,13,12'hFFF)}; #1;
    chk("R10", "update inc saturates", cmd_ready, 4'b0001);
    idle();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule